// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the card-side clock of an SD/MMC host from the system clock. A single ten-bit control word sets how the clock runs. Bits 6:0 hold the divider `d`, bit 7 is a card-mode flag, bit 8 is a stop flag and bit 9 is a high-speed flag. The control word is written through a one-cycle write strobe and can always be read back. The card clock runs at f_sys / (2·(d+1)) with equal high and low phases. Its fastest rate is half the system clock, at `d` = 0, and its slowest is at `d` = 127.

A small state machine has three states. In STOP the card clock is held low. In LOW the clock is low while a phase counter runs. In HIGH the clock is high while the counter runs. The transitions are:
- GO: STOP to LOW, when the stop flag is clear.
- HALT_LOW: LOW to STOP, when the stop flag is set.
- RISE: LOW to HIGH, when the counter reaches the divider.
- FALL: HIGH to LOW, when the counter reaches the divider and the stop flag is clear.
- HALT_HIGH: HIGH to STOP, when the counter reaches the divider and the stop flag is set.

The divider value in use is captured only on GO and FALL, so a new setting always starts at the beginning of a low phase. A one-cycle strobe warns the command and data shifters one system clock before each rising card-clock edge.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, card_clk and card_clk_rise are 0 and ctl_rdata reads 0x17F: divider 127, stop flag (bit 8) set, mode bits clear.
- R2: A write with ctl_we high stores all ten bits of ctl_wdata. The new value is visible on ctl_rdata one cycle later.
- R3: While running with divider `d`, every high phase and every low phase of card_clk lasts exactly d+1 system cycles.
- R4: With divider 0, card_clk toggles on every system cycle, which is half the system clock rate.
- R5: With divider 127, each phase lasts 128 cycles, giving a period of 256 system cycles.
- R6: Setting the stop flag during a low phase keeps card_clk low from then on. Setting it during a high phase lets that high phase finish at its full length, and card_clk then stays low. card_clk_rise stays 0 while the clock is stopped.
- R7: Clearing the stop flag restarts the clock with a low phase. The first rising edge of card_clk occurs d+2 system cycles after the edge that stores the write.
- R8: A divider written while the clock runs does not change the current low phase or the high phase after it. It takes effect from the next low phase.
- R9: card_clk_rise is high for exactly one system cycle, the cycle just before each rising edge of card_clk, and at no other time.
- R10: The card-mode bit (bit 7) and the high-speed bit (bit 9) are stored and read back but have no effect on the card clock timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word to store |
| ctl_rdata | output | 10 | Current control word |
| card_clk | output | 1 | Divided card clock, 50% duty |
| card_clk_rise | output | 1 | Pulse one cycle before each card_clk rise |

## Verification
A write is stored on the edge that samples ctl_we, so readback is due one cycle later. A change to the stop flag reaches the state machine one edge after that. After a restart the first rise is due d+2 edges after the storing edge. The strobe leads each rise by exactly one cycle. The bench drives inputs on the falling edge and samples on later falling edges. It measures each phase by counting consecutive samples at one level, and for each scenario it first skips phases that may still run with the previous divider.

// File: rtl/sdclk_gen_pkg.sv
package sdclk_gen_pkg;
    // Default divider field width
    localparam int CKG_DIV_W_DEF = 7;

    typedef enum logic [1:0] {
        CK_STOP = 2'd0,
        CK_LOW  = 2'd1,
        CK_HIGH = 2'd2
    } ck_state_e;
endpackage

// File: rtl/sdclk_ctlreg.sv
module sdclk_ctlreg #(
    parameter int DIV_W = 7,
    localparam int CTL_W = DIV_W + 3,
    parameter logic [CTL_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/sdclk_phase_cnt.sv
module sdclk_phase_cnt #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] limit,
    output logic             at_term
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_term = (cnt_q == limit);
endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq
    import sdclk_gen_pkg::*;
#(
    parameter int DIV_W = 7,
    parameter logic [DIV_W-1:0] RST_DIV = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [DIV_W-1:0] div_req,
    input  logic             at_term,
    output logic [DIV_W-1:0] div_use,
    output logic             cnt_clr,
    output logic             card_clk,
    output logic             card_clk_rise
);
    ck_state_e        state_q, state_n;
    logic [DIV_W-1:0] div_q;
    logic             load_div;

    // State register, plus the divider value in use
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_STOP;
            div_q   <= RST_DIV;
        end else begin
            state_q <= state_n;
            if (load_div) begin
                div_q <= div_req;
            end
        end
    end

    // Next state
    always_comb begin
        state_n  = state_q;
        cnt_clr  = 1'b0;
        load_div = 1'b0;
        unique case (state_q)
            CK_STOP: begin
                cnt_clr = 1'b1;
                if (!stop_req) begin            // GO
                    state_n  = CK_LOW;
                    load_div = 1'b1;
                end
            end
            CK_LOW: begin
                if (stop_req) begin             // HALT_LOW
                    state_n = CK_STOP;
                    cnt_clr = 1'b1;
                end else if (at_term) begin     // RISE
                    state_n = CK_HIGH;
                    cnt_clr = 1'b1;
                end
            end
            CK_HIGH: begin
                if (at_term) begin
                    cnt_clr = 1'b1;
                    if (stop_req) begin         // HALT_HIGH
                        state_n = CK_STOP;
                    end else begin              // FALL
                        state_n  = CK_LOW;
                        load_div = 1'b1;
                    end
                end
            end
            default: begin
                state_n = CK_STOP;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        card_clk      = (state_q == CK_HIGH);
        card_clk_rise = (state_q == CK_LOW) && at_term && !stop_req;
    end

    assign div_use = div_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_gen_pkg::*;
#(
    parameter int DIV_W = CKG_DIV_W_DEF,
    localparam int CTL_W = DIV_W + 3,
    localparam int MODE_BIT = DIV_W,
    localparam int STOP_BIT = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             card_clk,
    output logic             card_clk_rise
);
    localparam logic [DIV_W-1:0] RST_DIV = '1;
    localparam logic [CTL_W-1:0] RST_CTL =
        CTL_W'((1 << STOP_BIT) | ((1 << DIV_W) - 1));

    logic [CTL_W-1:0] ctl_q;
    logic [DIV_W-1:0] div_use;
    logic             cnt_clr;
    logic             at_term;

    sdclk_ctlreg #(.DIV_W(DIV_W), .RST_VAL(RST_CTL)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .q     (ctl_q)
    );

    sdclk_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .limit   (div_use),
        .at_term (at_term)
    );

    sdclk_seq #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (ctl_q[STOP_BIT]),
        .div_req       (ctl_q[DIV_W-1:0]),
        .at_term       (at_term),
        .div_use       (div_use),
        .cnt_clr       (cnt_clr),
        .card_clk      (card_clk),
        .card_clk_rise (card_clk_rise)
    );

    assign ctl_rdata = ctl_q;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
    parameter int DIV_W = 7,
    localparam int CTL_W = DIV_W + 3,
    localparam int STOP_BIT = DIV_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             card_clk,
    input logic             card_clk_rise
);
    logic        prev_clk;
    logic [15:0] hi_cnt, lo_cnt, lo_len;
    logic        clean, lo_ok;
    wire         stop_now = ctl_rdata[STOP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk <= 1'b0;
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            lo_len   <= '0;
            clean    <= 1'b0;
            lo_ok    <= 1'b0;
        end else begin
            prev_clk <= card_clk;
            if (card_clk) begin
                lo_cnt <= '0;
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
            end
            if (card_clk && !prev_clk) begin
                lo_len <= lo_cnt;
                lo_ok  <= clean && !stop_now;
            end
            if (stop_now) begin
                clean <= 1'b0;
            end else if (!card_clk && prev_clk) begin
                clean <= 1'b1;
            end
        end
    end

    // R2: readback follows a write one cycle later
    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_rdata == $past(ctl_wdata)));

    // R3: a high phase matches the uninterrupted low phase before it
    p_equal_phases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk && prev_clk && lo_ok) |-> (hi_cnt == lo_len));

    // R6: a stopped, low clock stays low
    p_stop_holds_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && !card_clk) |=> !card_clk);

    // R9: strobe precedes a rise
    p_strobe_then_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_rise |=> $rose(card_clk));

    // R9: every rise was announced
    p_rise_announced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> $past(card_clk_rise));
endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .ctl_rdata     (ctl_rdata),
    .card_clk      (card_clk),
    .card_clk_rise (card_clk_rise)
);

// File: tb/sim_sdclk_gen.sv
`timescale 1ns/1ps
module sim_sdclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [9:0] ctl_wdata = '0;
    logic [9:0] ctl_rdata;
    logic       card_clk, card_clk_rise;

    int total = 0;
    int bad = 0;
    int strobe_err = 0;
    int cyc = 0;
    logic prev_clk = 1'b0, prev_rise = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sdclk_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .ctl_rdata     (ctl_rdata),
        .card_clk      (card_clk),
        .card_clk_rise (card_clk_rise)
    );

    // R9 monitor: strobe and rise must pair one cycle apart
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rise && !(card_clk && !prev_clk)) strobe_err++;
            if (card_clk && !prev_clk && !prev_rise) strobe_err++;
            prev_clk  = card_clk;
            prev_rise = card_clk_rise;
        end else begin
            prev_clk  = 1'b0;
            prev_rise = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic to_rise();
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (card_clk == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stays_low(input string tag, input int cycles);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (card_clk || card_clk_rise) hits++;
        end
        chk(tag, hits, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset rdata", int'(ctl_rdata), 'h17F);
        chk("R1 reset card_clk", int'(card_clk), 0);
        stays_low("R1 idle after reset", 300);
    endtask

    task automatic t_div(input int d, input string tag);
        int hi, lo;
        wr(10'(d));
        to_rise();
        to_rise();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        chk({tag, " high length"}, hi, d + 1);
        chk({tag, " low length"}, lo, d + 1);
    endtask

    task automatic t_div_change();
        int n, hi;
        wr(10'd9);
        to_rise();
        to_rise();
        while (card_clk) @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = 10'd2;
        n = 0;
        do begin
            n++;
            @(negedge clk);
            ctl_we = 1'b0;
        end while (!card_clk && n < 1000);
        chk("R8 current low keeps old", n, 10);
        run_len(1'b1, hi);
        chk("R8 next high keeps old", hi, 10);
        run_len(1'b0, n);
        chk("R8 new low", n, 3);
        run_len(1'b1, hi);
        chk("R8 new high", hi, 3);
    endtask

    task automatic t_stop_high();
        int n;
        to_rise();
        ctl_we = 1'b1;
        ctl_wdata = 10'h100 | 10'd2;
        n = 0;
        do begin
            n++;
            @(negedge clk);
            ctl_we = 1'b0;
        end while (card_clk && n < 1000);
        chk("R6 high phase completes", n, 3);
        stays_low("R6 stopped after high", 200);
    endtask

    task automatic t_restart();
        int k;
        wr(10'd5);
        chk("R2 readback", int'(ctl_rdata), 5);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!card_clk && k < 50);
        chk("R7 first rise delay", k, 7);
    endtask

    task automatic t_stop_low();
        while (card_clk) @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = 10'h105;
        @(negedge clk);
        ctl_we = 1'b0;
        stays_low("R6 stopped in low", 200);
    endtask

    task automatic t_mode_bits();
        int hi, lo;
        wr(10'h284);
        chk("R10 mode bits readback", int'(ctl_rdata), 'h284);
        to_rise();
        to_rise();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        chk("R10 high unaffected", hi, 5);
        chk("R10 low unaffected", lo, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_div(0, "R4 div0");
        t_div(3, "R3 div3");
        t_div(127, "R5 div127");
        t_div_change();
        t_stop_high();
        t_restart();
        t_stop_low();
        t_mode_bits();
        chk("R9 strobe pairing errors", strobe_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule